// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer with Tail-Chaining

This block steers a small processor core into and out of interrupt handlers. Requests are latched as pending bits, each with its own priority. The winning request causes the block to save the core's eight-word interrupted context on the stack through a write port. It then reads the handler address from a vector table through a read port and hands that address to the core.

A more urgent request that shows up while the entry is still in progress does not restart anything. The frame being written is the same for any handler, so stacking simply runs to completion. Only the table read is redone if it returned the address of the request that has since been outranked.

When the core reports that a handler has finished, the block either reads the saved frame back to the core and resumes the interrupted thread, or, if another request is pending, jumps straight to that handler with one table read. The return code that the core sees on handler entry is kept across such a jump, including any change the previous handler made to it.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `sp_out` equals `SP_RESET` and `handler_lr` equals `EXC_RET_INIT`. `mw_en`, `mr_req`, `handler_start`, `restore_en` and `thread_resume` are all low.
- R2: Among pending requests, the one with the numerically lowest priority (`irq_prio[PRIO_W*i +: PRIO_W]`) is serviced first. A tie goes to the lower request index.
- R3: On entry from the thread, `sp_out` drops by 32. Exactly eight writes follow at addresses `sp_out + 4*k`, k = 0..7, in ascending order, each carrying context word k (`ctx_words[32*k +: 32]`).
- R4: The stack receives only the core's context words; the stacked word 5 is the interrupted code's return address taken from `ctx_words`. On entry from the thread, `handler_lr` holds `EXC_RET_INIT`.
- R5: After stacking, one read is issued at `VEC_BASE + 4*index` of the winning request. `handler_start` pulses with `handler_addr` equal to the data returned.
- R6: A higher-priority request raised during stacking leaves the stacking unchanged (still eight writes). The only vector read made is for the new winner.
- R7: If a higher-priority request arrives while a vector read is outstanding, the vector read is repeated for the new winner. The handler starts at the new winner's address.
- R8: A request's pending bit is cleared when its vector read completes and its handler starts, so each request is serviced exactly once.
- R9: A handler return while a request is pending produces no stack writes and no frame reads. Only a vector read is made before the next `handler_start`.
- R10: A value written to the return code through `lr_wr` during a handler is presented unchanged on `handler_lr` when the tail-chained handler starts.
- R11: A handler return with nothing pending reads the eight words back from `sp_out + 4*k` in order, presenting each on `restore_data` with `restore_idx` = k. `thread_resume` pulses with the last word, and `sp_out` is restored by +32.
- R12: Once a handler has started, a new request of any priority causes no stack write, no read and no handler start until that handler returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set | input | N_IRQ | One-cycle pulses that mark requests pending |
| irq_prio | input | N_IRQ*PRIO_W | Priority per request, lower is more urgent |
| ctx_words | input | 256 | Eight context words of the interrupted code, word k at bits 32k+31:32k |
| mw_en | output | 1 | Stack write request |
| mw_addr | output | 32 | Stack write byte address |
| mw_data | output | 32 | Stack write data |
| mw_ready | input | 1 | Stack write accepted this cycle |
| mr_req | output | 1 | One-cycle read request |
| mr_addr | output | 32 | Read byte address (vector table or stack) |
| mr_valid | input | 1 | Read data returned this cycle |
| mr_data | input | 32 | Read data |
| handler_start | output | 1 | Pulse: core begins handler at handler_addr |
| handler_addr | output | 32 | Handler entry address |
| handler_lr | output | 32 | Return code the handler receives in its link register |
| handler_ret | input | 1 | Pulse: running handler has finished |
| lr_wr | input | 1 | Handler overwrites its return code |
| lr_wdata | input | 32 | New return code |
| restore_en | output | 1 | Pulse: one restored context word is valid |
| restore_idx | output | 3 | Index of the restored word |
| restore_data | output | 32 | Restored word |
| thread_resume | output | 1 | Pulse: interrupted thread resumes |
| sp_out | output | 32 | Current stack pointer |

## Verification
The hardest case to reach is a more urgent request arriving in the few cycles between issuing a vector read and its return, because the window depends on the memory latency. The bench memory answers reads after a fixed delay. A scenario waits until it observes the first vector read on the port and raises the urgent request on the next cycle, so the pending set changes while the read is in flight. Arrival during stacking is reached the same way, by counting observed stack writes before raising the second request.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int FRAME_WORDS = 8;
    localparam int FRAME_BYTES = FRAME_WORDS * 4;
    localparam int WIDX_W      = $clog2(FRAME_WORDS);

    typedef enum logic [2:0] {
        S_IDLE,
        S_STACK,
        S_VFETCH,
        S_HANDLER,
        S_TCHAIN,
        S_UNSTACK
    } seq_state_t;

    typedef struct packed {
        logic              en;
        logic [WIDX_W-1:0] idx;
        logic [31:0]       data;
    } restore_t;

    function automatic logic [31:0] word_off(input logic [WIDX_W-1:0] w);
        return {{(32-WIDX_W-2){1'b0}}, w, 2'b00};
    endfunction

endpackage

// File: rtl/exc_pend_arb.sv
module exc_pend_arb #(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 3,
    localparam int IRQ_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_IRQ-1:0]        set,
    input  logic [N_IRQ*PRIO_W-1:0] prio,
    input  logic                    clr_en,
    input  logic [IRQ_W-1:0]        clr_idx,
    output logic                    best_valid,
    output logic [IRQ_W-1:0]        best_idx
);

    logic [N_IRQ-1:0]  pend;
    logic [N_IRQ-1:0]  clr_mask;
    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        clr_mask = '0;
        if (clr_en) clr_mask[clr_idx] = 1'b1;
    end

    // a fresh request wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_mask) | set;
    end

    // strict less-than keeps the lower index on equal priority
    always_comb begin
        best_valid = 1'b0;
        best_idx   = '0;
        best_prio  = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (pend[i] && (!best_valid || prio[i*PRIO_W +: PRIO_W] < best_prio)) begin
                best_valid = 1'b1;
                best_idx   = IRQ_W'(i);
                best_prio  = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    assert_winner_pending_R2: assert property (@(posedge clk) disable iff (rst)
        best_valid |-> pend[best_idx]);

    assert_clear_only_pending_R8: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> pend[clr_idx]);

    assert_clear_takes_effect_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set[clr_idx]) |=> !pend[$past(clr_idx)]);

endmodule

// File: rtl/exc_stack_ptr.sv
module exc_stack_ptr
    import exc_seq_pkg::*;
#(
    parameter logic [31:0] SP_RESET = 32'h2000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec,
    input  logic              inc,
    input  logic [WIDX_W-1:0] widx,
    output logic [31:0]       sp,
    output logic [31:0]       word_addr
);

    always_ff @(posedge clk) begin
        if (rst)      sp <= SP_RESET;
        else if (dec) sp <= sp - 32'(FRAME_BYTES);
        else if (inc) sp <= sp + 32'(FRAME_BYTES);
    end

    assign word_addr = sp + word_off(widx);

    assert_sp_push_R3: assert property (@(posedge clk) disable iff (rst)
        dec |=> sp == $past(sp) - 32'(FRAME_BYTES));

    assert_sp_pop_R11: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec) |=> sp == $past(sp) + 32'(FRAME_BYTES));

    assert_no_push_pop_R3: assert property (@(posedge clk) disable iff (rst)
        !(inc && dec));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int          N_IRQ        = 8,
    parameter int          PRIO_W       = 3,
    parameter logic [31:0] VEC_BASE     = 32'h0000_0040,
    parameter logic [31:0] SP_RESET     = 32'h2000_1000,
    parameter logic [31:0] EXC_RET_INIT = 32'hFFFF_FFF9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_IRQ-1:0]        irq_set,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [FRAME_WORDS*32-1:0] ctx_words,
    output logic                    mw_en,
    output logic [31:0]             mw_addr,
    output logic [31:0]             mw_data,
    input  logic                    mw_ready,
    output logic                    mr_req,
    output logic [31:0]             mr_addr,
    input  logic                    mr_valid,
    input  logic [31:0]             mr_data,
    output logic                    handler_start,
    output logic [31:0]             handler_addr,
    output logic [31:0]             handler_lr,
    input  logic                    handler_ret,
    input  logic                    lr_wr,
    input  logic [31:0]             lr_wdata,
    output logic                    restore_en,
    output logic [WIDX_W-1:0]       restore_idx,
    output logic [31:0]             restore_data,
    output logic                    thread_resume,
    output logic [31:0]             sp_out
);

    localparam int IRQ_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(FRAME_WORDS - 1);

    seq_state_t        st;
    logic [WIDX_W-1:0] cnt;
    logic              rd_busy;
    logic [IRQ_W-1:0]  fetch_idx;
    logic [31:0]       exc_ret_q;
    logic              hs_q;
    logic [31:0]       haddr_q;
    restore_t          rs_q;
    logic              resume_q;

    logic              best_valid;
    logic [IRQ_W-1:0]  best_idx;
    logic              fetching, last, vec_back, vec_ok, sp_dec, sp_inc;
    logic [31:0]       word_addr;
    logic [31:0]       ctx_arr [FRAME_WORDS];

    always_comb begin
        for (int k = 0; k < FRAME_WORDS; k++) ctx_arr[k] = ctx_words[32*k +: 32];
    end

    assign fetching = (st == S_VFETCH) || (st == S_TCHAIN);
    assign last     = (cnt == LAST_W);
    assign vec_back = fetching && rd_busy && mr_valid;
    // the read answered for the request that is still the winner
    assign vec_ok   = vec_back && (best_idx == fetch_idx);
    assign sp_dec   = (st == S_IDLE) && best_valid;
    assign sp_inc   = (st == S_UNSTACK) && rd_busy && mr_valid && last;

    exc_pend_arb #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .set        (irq_set),
        .prio       (irq_prio),
        .clr_en     (vec_ok),
        .clr_idx    (fetch_idx),
        .best_valid (best_valid),
        .best_idx   (best_idx)
    );

    exc_stack_ptr #(.SP_RESET(SP_RESET)) u_sp (
        .clk       (clk),
        .rst       (rst),
        .dec       (sp_dec),
        .inc       (sp_inc),
        .widx      (cnt),
        .sp        (sp_out),
        .word_addr (word_addr)
    );

    assign mw_en   = (st == S_STACK);
    assign mw_addr = word_addr;
    assign mw_data = ctx_arr[cnt];
    assign mr_req  = !rd_busy && (fetching ? best_valid : (st == S_UNSTACK));
    assign mr_addr = fetching ? (VEC_BASE + ({{(32-IRQ_W){1'b0}}, best_idx} << 2))
                              : word_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cnt       <= '0;
            rd_busy   <= 1'b0;
            fetch_idx <= '0;
            exc_ret_q <= EXC_RET_INIT;
            hs_q      <= 1'b0;
            haddr_q   <= '0;
            rs_q      <= '0;
            resume_q  <= 1'b0;
        end else begin
            hs_q     <= 1'b0;
            rs_q.en  <= 1'b0;
            resume_q <= 1'b0;
            if (mr_req) begin
                rd_busy   <= 1'b1;
                fetch_idx <= best_idx;
            end
            case (st)
                S_IDLE: begin
                    if (best_valid) begin
                        st        <= S_STACK;
                        cnt       <= '0;
                        exc_ret_q <= EXC_RET_INIT;
                    end
                end
                S_STACK: begin
                    if (mw_ready) begin
                        cnt <= cnt + 1'b1;
                        if (last) st <= S_VFETCH;
                    end
                end
                S_VFETCH, S_TCHAIN: begin
                    if (vec_back) begin
                        rd_busy <= 1'b0;
                        if (vec_ok) begin
                            hs_q    <= 1'b1;
                            haddr_q <= mr_data;
                            st      <= S_HANDLER;
                        end
                    end
                end
                S_HANDLER: begin
                    if (lr_wr) exc_ret_q <= lr_wdata;
                    if (handler_ret) begin
                        cnt <= '0;
                        st  <= best_valid ? S_TCHAIN : S_UNSTACK;
                    end
                end
                S_UNSTACK: begin
                    if (rd_busy && mr_valid) begin
                        rd_busy   <= 1'b0;
                        rs_q.en   <= 1'b1;
                        rs_q.idx  <= cnt;
                        rs_q.data <= mr_data;
                        cnt       <= cnt + 1'b1;
                        if (last) begin
                            resume_q <= 1'b1;
                            st       <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign handler_start = hs_q;
    assign handler_addr  = haddr_q;
    assign handler_lr    = exc_ret_q;
    assign restore_en    = rs_q.en;
    assign restore_idx   = rs_q.idx;
    assign restore_data  = rs_q.data;
    assign thread_resume = resume_q;

    assert_start_enters_handler_R5: assert property (@(posedge clk) disable iff (rst)
        handler_start |-> st == S_HANDLER);

    assert_handler_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (st == S_HANDLER) |-> (!mw_en && !mr_req));

    assert_ports_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(mw_en && mr_req));

    assert_resume_with_last_word_R11: assert property (@(posedge clk) disable iff (rst)
        thread_resume |-> (restore_en && restore_idx == LAST_W && st == S_IDLE));

    assert_lr_kept_on_chain_R10: assert property (@(posedge clk) disable iff (rst)
        (st == S_TCHAIN) |=> $stable(exc_ret_q));

endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
    import exc_seq_pkg::*;

    localparam int          N   = 8;
    localparam int          PW  = 3;
    localparam logic [31:0] VB  = 32'h0000_0040;
    localparam logic [31:0] SPR = 32'h2000_1000;
    localparam logic [31:0] ERI = 32'hFFFF_FFF9;
    localparam logic [31:0] STK_LO = SPR - 32;

    logic clk = 0, rst = 1;
    logic [N-1:0] irq_set = '0;
    logic [N*PW-1:0] irq_prio = '0;
    logic [FRAME_WORDS*32-1:0] ctx_words = '0;
    logic mw_en, mw_ready = 1'b1, mr_req, mr_valid = 1'b0;
    logic [31:0] mw_addr, mw_data, mr_addr, mr_data = '0;
    logic handler_start, handler_ret = 1'b0, lr_wr = 1'b0;
    logic [31:0] handler_addr, handler_lr, lr_wdata = '0, restore_data, sp_out;
    logic restore_en, thread_resume;
    logic [WIDX_W-1:0] restore_idx;

    always #2 clk = ~clk;

    exc_entry_seq #(.N_IRQ(N), .PRIO_W(PW), .VEC_BASE(VB), .SP_RESET(SPR), .EXC_RET_INIT(ERI)) dut (
        .clk(clk), .rst(rst), .irq_set(irq_set), .irq_prio(irq_prio), .ctx_words(ctx_words),
        .mw_en(mw_en), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ready(mw_ready),
        .mr_req(mr_req), .mr_addr(mr_addr), .mr_valid(mr_valid), .mr_data(mr_data),
        .handler_start(handler_start), .handler_addr(handler_addr), .handler_lr(handler_lr),
        .handler_ret(handler_ret), .lr_wr(lr_wr), .lr_wdata(lr_wdata),
        .restore_en(restore_en), .restore_idx(restore_idx), .restore_data(restore_data),
        .thread_resume(thread_resume), .sp_out(sp_out));

    int tests = 0, fails = 0;
    int w_cnt, v_cnt, u_cnt, h_cnt, r_cnt, res_cnt;
    logic [31:0] w_addr [16], w_data [16], v_addr [8], h_addr [8], h_lr [8], r_data [8];
    logic [31:0] stk [8];
    int rd_lat = 0;
    logic rd_pend = 0;
    logic [31:0] rd_a;

    function automatic logic [31:0] hvec(input int idx);
        return 32'h0000_1000 + 32'(idx) * 32'h100;
    endfunction

    function automatic logic [31:0] lookup(input logic [31:0] a);
        if (a >= VB && a < VB + 4*N) return hvec(int'((a - VB) >> 2));
        if (a >= STK_LO && a < SPR) return stk[3'((a - STK_LO) >> 2)];
        return 32'hDEAD_BEEF;
    endfunction

    // port monitor and read-memory model, both at the falling edge
    always @(negedge clk) begin
        mr_valid = 1'b0;
        if (rd_pend) begin
            if (rd_lat == 1) begin
                mr_valid = 1'b1;
                mr_data  = lookup(rd_a);
                rd_pend  = 1'b0;
            end else rd_lat--;
        end
        if (!rst) begin
            if (mw_en && mw_ready) begin
                if (w_cnt < 16) begin w_addr[w_cnt] = mw_addr; w_data[w_cnt] = mw_data; end
                if (mw_addr >= STK_LO && mw_addr < SPR) stk[3'((mw_addr - STK_LO) >> 2)] = mw_data;
                w_cnt++;
            end
            if (mr_req) begin
                if (mr_addr >= VB && mr_addr < VB + 4*N) begin
                    if (v_cnt < 8) v_addr[v_cnt] = mr_addr;
                    v_cnt++;
                end else u_cnt++;
                rd_pend = 1'b1; rd_lat = 4; rd_a = mr_addr;
            end
            if (handler_start) begin
                if (h_cnt < 8) begin h_addr[h_cnt] = handler_addr; h_lr[h_cnt] = handler_lr; end
                h_cnt++;
            end
            if (restore_en) begin r_data[restore_idx] = restore_data; r_cnt++; end
            if (thread_resume) res_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        w_cnt = 0; v_cnt = 0; u_cnt = 0; h_cnt = 0; r_cnt = 0; res_cnt = 0;
    endtask

    task automatic set_ctx(input logic [31:0] base);
        for (int k = 0; k < FRAME_WORDS; k++) ctx_words[32*k +: 32] = base + 32'(k);
    endtask

    task automatic raise(input int idx, input int p);
        @(negedge clk);
        irq_prio[idx*PW +: PW] = PW'(p);
        irq_set[idx] = 1'b1;
        @(negedge clk);
        irq_set = '0;
    endtask

    task automatic ret_handler();
        @(negedge clk); handler_ret = 1'b1;
        @(negedge clk); handler_ret = 1'b0;
    endtask

    task automatic wait_h(input int n);
        for (int t = 0; t < 400 && h_cnt < n; t++) @(posedge clk);
    endtask

    task automatic wait_resume();
        for (int t = 0; t < 400 && res_cnt < 1; t++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sp_out == SPR, "R1 sp", sp_out, SPR);
        chk(handler_lr == ERI, "R1 lr", handler_lr, ERI);
        chk({mw_en, mr_req, handler_start, restore_en, thread_resume} == 5'b0, "R1 idle outputs",
            {27'b0, mw_en, mr_req, handler_start, restore_en, thread_resume}, 32'h0);
    endtask

    task automatic t_basic();
        bit ok = 1;
        clear_logs(); set_ctx(32'hA000_0100);
        raise(2, 3);
        wait_h(1);
        chk(w_cnt == 8, "R3 write count", 32'(w_cnt), 8);
        for (int k = 0; k < 8; k++)
            if (w_addr[k] != STK_LO + 32'(4*k) || w_data[k] != 32'hA000_0100 + 32'(k)) ok = 0;
        chk(ok, "R3 frame addr/data", w_addr[0], STK_LO);
        chk(sp_out == STK_LO, "R3 sp after push", sp_out, STK_LO);
        chk(w_data[5] == 32'hA000_0105 && w_data[5] != ERI, "R4 stacked return word", w_data[5], 32'hA000_0105);
        chk(h_lr[0] == ERI, "R4 entry return code", h_lr[0], ERI);
        chk(v_cnt == 1 && v_addr[0] == VB + 8, "R5 vector read", v_addr[0], VB + 8);
        chk(h_addr[0] == hvec(2), "R5 handler addr", h_addr[0], hvec(2));
        ret_handler();
        wait_resume();
        ok = 1;
        for (int k = 0; k < 8; k++) if (r_data[k] != 32'hA000_0100 + 32'(k)) ok = 0;
        chk(u_cnt == 8 && r_cnt == 8, "R11 unstack reads", 32'(u_cnt), 8);
        chk(ok, "R11 restored words", r_data[0], 32'hA000_0100);
        chk(res_cnt == 1 && sp_out == SPR, "R11 sp restored", sp_out, SPR);
    endtask

    task automatic t_prio();
        clear_logs(); set_ctx(32'hB000_0000);
        @(negedge clk);
        irq_prio[5*PW +: PW] = 3'd1; irq_prio[3*PW +: PW] = 3'd1; irq_prio[1*PW +: PW] = 3'd2;
        irq_set = 8'b0010_1010;
        @(negedge clk); irq_set = '0;
        wait_h(1);
        chk(h_addr[0] == hvec(3), "R2 tie to lower index", h_addr[0], hvec(3));
        ret_handler(); wait_h(2);
        chk(h_addr[1] == hvec(5), "R2 second by priority", h_addr[1], hvec(5));
        chk(w_cnt == 8 && u_cnt == 0, "R9 chain no stack traffic", 32'(w_cnt*100 + u_cnt), 800);
        ret_handler(); wait_h(3);
        chk(h_addr[2] == hvec(1), "R2 lowest urgency last", h_addr[2], hvec(1));
        ret_handler(); wait_resume();
        chk(h_cnt == 3 && v_cnt == 3, "R8 each serviced once", 32'(h_cnt), 3);
        chk(u_cnt == 8, "R11 final unstack", 32'(u_cnt), 8);
    endtask

    task automatic t_late_stack();
        clear_logs(); set_ctx(32'hC000_0000);
        raise(6, 5);
        for (int t = 0; t < 100 && w_cnt < 3; t++) @(posedge clk);
        raise(0, 2);
        wait_h(1);
        chk(w_cnt == 8, "R6 stacking unchanged", 32'(w_cnt), 8);
        chk(v_cnt == 1 && v_addr[0] == VB, "R6 single vector read", v_addr[0], VB);
        chk(h_addr[0] == hvec(0), "R6 late winner served", h_addr[0], hvec(0));
        ret_handler(); wait_h(2);
        chk(h_addr[1] == hvec(6) && w_cnt == 8, "R9 chain to earlier request", h_addr[1], hvec(6));
        ret_handler(); wait_resume();
    endtask

    task automatic t_late_fetch();
        clear_logs(); set_ctx(32'hD000_0000);
        raise(4, 4);
        for (int t = 0; t < 100 && v_cnt < 1; t++) @(posedge clk);
        raise(7, 0);
        wait_h(1);
        chk(v_cnt == 2 && v_addr[1] == VB + 28, "R7 vector refetch", v_addr[1], VB + 28);
        chk(h_addr[0] == hvec(7) && w_cnt == 8, "R7 handler of new winner", h_addr[0], hvec(7));
        @(negedge clk); lr_wr = 1'b1; lr_wdata = 32'hFFFF_FFFD;
        @(negedge clk); lr_wr = 1'b0;
        ret_handler(); wait_h(2);
        chk(h_addr[1] == hvec(4), "R9 chain after refetch", h_addr[1], hvec(4));
        chk(h_lr[1] == 32'hFFFF_FFFD, "R10 modified return code kept", h_lr[1], 32'hFFFF_FFFD);
        ret_handler(); wait_resume();
        chk(sp_out == SPR, "R11 sp after chain", sp_out, SPR);
    endtask

    task automatic t_no_preempt();
        clear_logs(); set_ctx(32'hE000_0000);
        raise(2, 6);
        wait_h(1);
        raise(0, 0);
        repeat (20) @(posedge clk);
        chk(h_cnt == 1 && w_cnt == 8 && v_cnt == 1, "R12 running handler kept",
            32'(h_cnt*100 + w_cnt*10 + v_cnt), 181);
        ret_handler(); wait_h(2);
        chk(h_addr[1] == hvec(0) && u_cnt == 0, "R9 chain to held request", h_addr[1], hvec(0));
        ret_handler(); wait_resume();
        chk(u_cnt == 8 && res_cnt == 1, "R11 resume after chain", 32'(u_cnt), 8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_logs();
        for (int k = 0; k < 8; k++) stk[k] = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_basic();
        t_prio();
        t_late_stack();
        t_late_fetch();
        t_no_preempt();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule